// File: doc/BRIEF.md
# Multi-channel shadowed PWM generator

This block produces one pulse-width-modulated output per channel, with a parameterised channel count. Each channel has three counts: a period, a duty (the number of high clocks at the start of each period) and an offset (a delay in clocks before the first period begins after a restart). Software programs the block over a simple 32-bit register port. Each access uses a one-cycle write or read strobe and a word-aligned byte address.

Channel count writes never act at once. They land in shadow registers and reach the running counters only when software writes a load command to the configuration register. A pending load is applied at the end of the current period of the lowest-numbered running channel. If no channel is running, or the core is held, it is applied on the next clock. Applying a load copies every channel's shadow values together and restarts all channels in phase, which keeps channels with harmonic periods aligned.

A hold bit in the configuration register keeps every counter at its start and every output low. The hold bit is set out of reset. Fixed registers give a magic identification word, a version word, a build ID, the implemented channel count and a free scratch word.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset, config (0x10) reads 0x1 (bit 0 hold set, bit 1 load-pending clear), every channel register reads 0 and every output is low.
- R2: Read data appears on `bus_rdata` at the clock edge that closes the cycle in which `bus_rd` is high, and holds until the next read. The fixed registers read as follows: 0x0C reads 0x601A3471; 0x00 reads major 1 in bits [23:16], minor in [15:8] and patch in [7:0]; 0x04 reads the build ID; 0x14 reads the channel count.
- R3: 0x08 reads back the last value written to it. Writes to unmapped addresses are ignored and those addresses read 0. This includes channel slots at or beyond the channel count (for example 0x70 with four channels).
- R4: While config bit 0 is 1, all outputs are low. When it is cleared, every channel starts its offset delay and then its first period.
- R5: For channel n, the period is at 0x40+12n, the duty at 0x44+12n and the offset at 0x48+12n. Writes to these registers read back at once but do not change any output until a load is applied.
- R6: A config write with bit 1 set requests a load. Config bit 1 then reads 1 until the load is applied, and reads 0 after it.
- R7: A pending load is applied at the edge that ends the last cycle of a period of the lowest-numbered channel with a nonzero period. It is applied on the next edge if the core is held or no channel has a nonzero period. All channels take their new counts at that edge and restart together.
- R8: With period P > 0 and duty D < P, an output is high for the first D clocks of every P-clock period.
- R9: A duty of at least the period gives a constant high output. A duty of 0 gives a constant low output. A period of 0 disables the channel and keeps its output low.
- R10: With offset O, an output stays low for O clocks after each restart before its first period begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | N_CH | One PWM output per channel |

## Verification
Read data is due one edge after the read strobe. The bench queues the expected word when it raises the strobe and compares it at the falling edge that follows the capturing edge. Output timing comes from a cycle model in the bench, updated at each rising edge from the bus inputs. The model decides whether a pending load lands at that edge, using period arithmetic on the lowest running channel, and it knows that new counts show up in the cycle right after that edge. The outputs are compared with this model at every falling edge. So the exact cycle of each commit, restart and offset expiry is checked rather than only the pulse shapes.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;

  localparam logic [31:0] MAGIC_WORD = 32'h601A3471;
  localparam logic [7:0]  VER_MAJOR  = 8'd1;

  localparam logic [15:0] A_VERSION  = 16'h0000;
  localparam logic [15:0] A_BUILD_ID = 16'h0004;
  localparam logic [15:0] A_SCRATCH  = 16'h0008;
  localparam logic [15:0] A_MAGIC    = 16'h000C;
  localparam logic [15:0] A_CONFIG   = 16'h0010;
  localparam logic [15:0] A_NCHAN    = 16'h0014;
  localparam logic [15:0] CHAN_BASE  = 16'h0040;
  localparam logic [15:0] CHAN_STEP  = 16'd12;

  typedef enum logic [1:0] {
    F_PER  = 2'd0,
    F_DUTY = 2'd1,
    F_OFF  = 2'd2,
    F_NONE = 2'd3
  } chan_field_e;

  typedef struct packed {
    logic        hit;
    logic [15:0] ch;
    chan_field_e fld;
  } chan_sel_t;

  // Map a byte address onto a channel slot and a field within it.
  function automatic chan_sel_t chan_decode(input logic [15:0] a, input int unsigned n_ch);
    chan_sel_t   s;
    logic [15:0] rel;
    logic [15:0] idx;
    logic [15:0] rem;
    rel   = a - CHAN_BASE;
    idx   = rel / CHAN_STEP;
    rem   = rel % CHAN_STEP;
    s.ch  = idx;
    s.fld = chan_field_e'(2'(rem >> 2));
    s.hit = (a >= CHAN_BASE) && (a[1:0] == 2'b00) && (32'(idx) < n_ch);
    return s;
  endfunction

  // Level of a running channel at count position pos.
  function automatic logic pwm_level(input logic [31:0] pos, input logic [31:0] per,
                                     input logic [31:0] duty);
    return (duty >= per) || (pos < duty);
  endfunction

endpackage

// File: rtl/pwmg_regfile.sv
module pwmg_regfile
  import pwmg_pkg::*;
#(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] ID_VALUE  = 32'h0000_0A5C,
  parameter logic [7:0]  VER_MINOR = 8'd2,
  parameter logic [7:0]  VER_PATCH = 8'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              commit,
  output logic              hold,
  output logic              load_pend,
  output logic              wr_load,
  output logic [CNT_W-1:0]  sh_per  [N_CH],
  output logic [CNT_W-1:0]  sh_duty [N_CH],
  output logic [CNT_W-1:0]  sh_off  [N_CH]
);

  localparam logic [31:0] VERSION_WORD = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};

  logic [15:0] a16;
  chan_sel_t   sel;
  logic        is_cfg;
  logic [31:0] scratch;
  logic [31:0] rd_mux;

  assign a16     = 16'(addr);
  assign sel     = chan_decode(a16, N_CH);
  assign is_cfg  = (a16 == A_CONFIG);
  assign wr_load = wr_en && is_cfg && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= 1'b1;
      load_pend <= 1'b0;
      scratch   <= '0;
    end else begin
      if (wr_en && is_cfg) hold <= wdata[0];
      if (wr_en && (a16 == A_SCRATCH)) scratch <= wdata;
      load_pend <= (load_pend && !commit) || wr_load;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_per[c]  <= '0;
        sh_duty[c] <= '0;
        sh_off[c]  <= '0;
      end else if (wr_en && sel.hit && (sel.ch == 16'(c))) begin
        case (sel.fld)
          F_PER:   sh_per[c]  <= wdata[CNT_W-1:0];
          F_DUTY:  sh_duty[c] <= wdata[CNT_W-1:0];
          F_OFF:   sh_off[c]  <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (a16)
      A_VERSION:  rd_mux = VERSION_WORD;
      A_BUILD_ID: rd_mux = ID_VALUE;
      A_SCRATCH:  rd_mux = scratch;
      A_MAGIC:    rd_mux = MAGIC_WORD;
      A_CONFIG:   rd_mux = {30'd0, load_pend, hold};
      A_NCHAN:    rd_mux = 32'(N_CH);
      default: begin
        for (int c = 0; c < N_CH; c++) begin
          if (sel.hit && (sel.ch == 16'(c))) begin
            case (sel.fld)
              F_PER:   rd_mux = 32'(sh_per[c]);
              F_DUTY:  rd_mux = 32'(sh_duty[c]);
              F_OFF:   rd_mux = 32'(sh_off[c]);
              default: ;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/pwmg_commit.sv
module pwmg_commit #(
  parameter int unsigned N_CH = 4
) (
  input  logic            hold,
  input  logic            load_pend,
  input  logic [N_CH-1:0] chan_en,
  input  logic [N_CH-1:0] chan_wrap,
  output logic            commit
);

  logic boundary;
  logic found;

  // The lowest-numbered running channel sets the period boundary.
  always_comb begin
    boundary = 1'b1;
    found    = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (!found && chan_en[i]) begin
        found    = 1'b1;
        boundary = chan_wrap[i];
      end
    end
  end

  assign commit = load_pend && (hold || boundary);

endmodule

// File: rtl/pwmg_channel.sv
module pwmg_channel
  import pwmg_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             commit,
  input  logic [CNT_W-1:0] sh_per,
  input  logic [CNT_W-1:0] sh_duty,
  input  logic [CNT_W-1:0] sh_off,
  output logic             chan_en,
  output logic             chan_wrap,
  output logic             pwm
);

  logic [CNT_W-1:0] a_per, a_duty, a_off;
  logic [CNT_W-1:0] cnt, dly;
  logic             at_end, running;

  assign at_end    = (cnt == a_per - 1'b1);
  assign chan_en   = (a_per != '0);
  assign running   = !hold && (dly == '0) && chan_en;
  assign chan_wrap = running && at_end;
  assign pwm       = running && pwm_level(32'(cnt), 32'(a_per), 32'(a_duty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_per  <= '0;
      a_duty <= '0;
      a_off  <= '0;
      cnt    <= '0;
      dly    <= '0;
    end else begin
      if (commit) begin
        a_per  <= sh_per;
        a_duty <= sh_duty;
        a_off  <= sh_off;
      end
      if (hold || commit) begin
        cnt <= '0;
        dly <= commit ? sh_off : a_off;
      end else if (dly != '0) begin
        dly <= dly - 1'b1;
      end else if (chan_en) begin
        cnt <= at_end ? '0 : cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen #(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] ID_VALUE  = 32'h0000_0A5C,
  parameter logic [7:0]  VER_MINOR = 8'd2,
  parameter logic [7:0]  VER_PATCH = 8'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_CH-1:0]   pwm_out
);

  logic             core_hold;
  logic             load_pend;
  logic             wr_load;
  logic             commit;
  logic [N_CH-1:0]  chan_en;
  logic [N_CH-1:0]  chan_wrap;
  logic [CNT_W-1:0] sh_per  [N_CH];
  logic [CNT_W-1:0] sh_duty [N_CH];
  logic [CNT_W-1:0] sh_off  [N_CH];

  pwmg_regfile #(
    .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .ID_VALUE(ID_VALUE), .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .commit(commit), .hold(core_hold), .load_pend(load_pend), .wr_load(wr_load),
    .sh_per(sh_per), .sh_duty(sh_duty), .sh_off(sh_off)
  );

  pwmg_commit #(.N_CH(N_CH)) u_commit (
    .hold(core_hold), .load_pend(load_pend),
    .chan_en(chan_en), .chan_wrap(chan_wrap), .commit(commit)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    pwmg_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .hold(core_hold), .commit(commit),
      .sh_per(sh_per[c]), .sh_duty(sh_duty[c]), .sh_off(sh_off[c]),
      .chan_en(chan_en[c]), .chan_wrap(chan_wrap[c]), .pwm(pwm_out[c])
    );
  end

endmodule

// File: rtl/pwmg_checker.sv
module pwmg_checker #(
  parameter int unsigned N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold,
  input logic            load_pend,
  input logic            commit,
  input logic            wr_load,
  input logic            rd_en,
  input logic [31:0]     rdata,
  input logic [N_CH-1:0] chan_en,
  input logic [N_CH-1:0] pwm_out
);

  // R4: a held core drives no output high
  a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (pwm_out == '0));

  // R6: a load request is visible as pending in the next cycle
  a_r6_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> load_pend);

  // R6: an applied load clears pending unless a new request arrives with it
  a_r6_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_load) |=> !load_pend);

  // R2: read data moves only in response to a read strobe
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R9: a channel with period 0 stays low
  for (genvar i = 0; i < N_CH; i++) begin : g_dis
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[i] |-> !pwm_out[i]);
  end

endmodule

bind pwm_shadow_gen pwmg_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(core_hold), .load_pend(load_pend),
  .commit(commit), .wr_load(wr_load), .rd_en(bus_rd), .rdata(bus_rdata),
  .chan_en(chan_en), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_shadow_gen.sv
`timescale 1ns/1ps
module sim_pwm_shadow_gen;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  always #2.5 clk = ~clk;

  pwm_shadow_gen #(.N_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  bit    mon_on = 0;
  string phase_tag = "R1";

  // ---------------- cycle model of the outputs ----------------
  int m_sp[NCH], m_sd[NCH], m_so[NCH];
  int m_per[NCH], m_duty[NCH], m_off[NCH];
  bit m_hold, m_pend;
  int cyc, anchor;

  function automatic bit exp_bit(int t, int c);
    if (m_per[c] == 0) return 1'b0;
    if (t < m_off[c]) return 1'b0;
    if (m_duty[c] >= m_per[c]) return 1'b1;
    return ((t - m_off[c]) % m_per[c]) < m_duty[c];
  endfunction

  function automatic bit m_boundary(int cur);
    for (int c = 0; c < NCH; c++) begin
      if (m_per[c] != 0) begin
        int t;
        t = cur - anchor;
        if (t < m_off[c]) return 1'b0;
        return ((t - m_off[c]) % m_per[c]) == (m_per[c] - 1);
      end
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 1'b1; m_pend = 1'b0; cyc = 0; anchor = 0;
      for (int c = 0; c < NCH; c++) begin
        m_sp[c] = 0; m_sd[c] = 0; m_so[c] = 0; m_per[c] = 0; m_duty[c] = 0; m_off[c] = 0;
      end
    end else begin
      int cur;
      cur = cyc;
      cyc = cyc + 1;
      if (m_pend && (m_hold || m_boundary(cur))) begin
        for (int c = 0; c < NCH; c++) begin
          m_per[c] = m_sp[c]; m_duty[c] = m_sd[c]; m_off[c] = m_so[c];
        end
        m_pend = 1'b0;
        anchor = cyc;
      end
      if (m_hold) anchor = cyc;
      if (bus_wr) begin
        if (bus_addr == 8'h10) begin
          m_hold = bus_wdata[0];
          if (bus_wdata[1]) m_pend = 1'b1;
        end
        for (int c = 0; c < NCH; c++) begin
          if (bus_addr == 8'(64 + 12*c)) m_sp[c] = int'(bus_wdata);
          if (bus_addr == 8'(68 + 12*c)) m_sd[c] = int'(bus_wdata);
          if (bus_addr == 8'(72 + 12*c)) m_so[c] = int'(bus_wdata);
        end
      end
    end
  end

  // Output monitor: one check per cycle against the model
  always @(negedge clk) begin
    if (rst_n && mon_on && !done) begin
      logic [3:0] e;
      for (int c = 0; c < NCH; c++) e[c] = m_hold ? 1'b0 : exp_bit(cyc - anchor, c);
      checks++;
      if (pwm_out !== e) begin
        fails++;
        $display("FAIL %s pwm_out cycle %0d actual=%b expected=%b", phase_tag, cyc, pwm_out, e);
      end
    end
  end

  // ---------------- read scoreboard ----------------
  logic [31:0] rq_exp[$];
  string       rq_tag[$];
  bit          rd_seen = 0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && rq_exp.size() > 0) begin
      logic [31:0] e;
      string t;
      e = rq_exp.pop_front();
      t = rq_tag.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s read actual=%08h expected=%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    rq_exp.push_back(e); rq_tag.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] a_p(int c); return 8'(64 + 12*c); endfunction
  function automatic logic [7:0] a_d(int c); return 8'(68 + 12*c); endfunction
  function automatic logic [7:0] a_o(int c); return 8'(72 + 12*c); endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 reset state
    phase_tag = "R1";
    rd(8'h10, 32'h1, "R1 config after reset");
    rd(a_p(0), 32'h0, "R1 ch0 period after reset");
    rd(a_o(3), 32'h0, "R1 ch3 offset after reset");
    idle(3);

    // R2 fixed registers
    phase_tag = "R2";
    rd(8'h0C, 32'h601A3471, "R2 magic");
    rd(8'h00, 32'h0001_0201, "R2 version");
    rd(8'h04, 32'h0000_0A5C, "R2 build id");
    rd(8'h14, 32'd4, "R2 channel count");

    // R3 scratch and ignored addresses
    phase_tag = "R3";
    wr(8'h08, 32'hC0FF_EE11);
    rd(8'h08, 32'hC0FF_EE11, "R3 scratch readback");
    wr(8'h18, 32'h1234);
    rd(8'h18, 32'h0, "R3 unmapped reads 0");
    wr(8'h70, 32'd5);
    rd(8'h70, 32'h0, "R3 channel slot beyond count");
    rd(8'h08, 32'hC0FF_EE11, "R3 scratch unaffected");

    // R4 load while held, then release
    phase_tag = "R4";
    wr(a_p(0), 32'd8); wr(a_d(0), 32'd4);
    wr(8'h10, 32'h3);
    idle(2);
    rd(8'h10, 32'h1, "R4 held load applied, still held");
    idle(10);
    phase_tag = "R8";
    wr(8'h10, 32'h0);
    idle(30);

    // R5 shadow writes without load
    phase_tag = "R5";
    wr(a_p(0), 32'd12); wr(a_d(0), 32'd5);
    wr(a_p(1), 32'd6);  wr(a_d(1), 32'd2); wr(a_o(1), 32'd3);
    rd(a_p(0), 32'd12, "R5 ch0 period shadow readback");
    rd(a_d(1), 32'd2, "R5 ch1 duty shadow readback");
    rd(a_o(1), 32'd3, "R5 ch1 offset shadow readback");
    idle(40);

    // R6/R7 deferred load at ch0 boundary
    phase_tag = "R7";
    wr(8'h10, 32'h2);
    rd(8'h10, 32'h2, "R6 load pending visible");
    idle(30);
    rd(8'h10, 32'h0, "R6 load pending cleared");
    idle(60);

    // R9 corner duties and disabled channel
    phase_tag = "R9";
    wr(a_d(0), 32'd12);
    wr(a_d(1), 32'd0);  wr(a_o(1), 32'd0);
    wr(a_p(2), 32'd5);  wr(a_d(2), 32'd9);
    wr(a_p(3), 32'd0);  wr(a_d(3), 32'd3);
    wr(8'h10, 32'h2);
    idle(60);

    // R10 offsets
    phase_tag = "R10";
    wr(a_p(0), 32'd10); wr(a_d(0), 32'd3); wr(a_o(0), 32'd4);
    wr(a_p(1), 32'd7);  wr(a_d(1), 32'd2); wr(a_o(1), 32'd9);
    wr(a_p(2), 32'd5);  wr(a_d(2), 32'd1); wr(a_o(2), 32'd0);
    wr(a_p(3), 32'd4);  wr(a_d(3), 32'd2); wr(a_o(3), 32'd1);
    wr(8'h10, 32'h2);
    idle(80);

    // R7 no channel running: immediate apply
    phase_tag = "R7";
    for (int c = 0; c < NCH; c++) begin
      wr(a_p(c), 32'd0); wr(a_o(c), 32'd0);
    end
    wr(8'h10, 32'h2);
    idle(20);
    wr(a_p(2), 32'd4); wr(a_d(2), 32'd1);
    wr(8'h10, 32'h2);
    idle(1);
    rd(8'h10, 32'h0, "R7 immediate apply with no running channel");
    idle(20);
    wr(a_p(2), 32'd9); wr(a_d(2), 32'd4);
    wr(a_p(0), 32'd3); wr(a_d(0), 32'd1);
    wr(8'h10, 32'h2);
    idle(50);

    // R4 hold mid-run, then release
    phase_tag = "R4";
    wr(8'h10, 32'h1);
    idle(10);
    rd(8'h10, 32'h1, "R4 hold readback");
    wr(8'h10, 32'h0);
    idle(30);

    idle(3);
    finish_run();
  end

endmodule